// File: doc/BRIEF.md
# Two-Lane Link Slave Transaction Decoder

This block is the receiving end of a two-lane, double-edge serial link that carries register writes and register reads from a host. The logic runs on a system clock at twice the link-clock rate. Each system-clock cycle stands for one link-clock edge, and the `linkRise` input marks the cycles that are rising edges. When the block is idle, a high level on lane 0 in a rising-edge cycle opens a transaction. The following samples give the direction, the address/data flag, the chip select and, for a write, a 16-bit payload split across the two lanes.

A write ends in a one-cycle strobe that carries the assembled word. A read raises a request to the register side, then takes over the lanes in place of the host, which has let them go. The block holds both lanes low until read data is offered on `rdReady`. It then sends a one-link-cycle start mark on both lanes, followed by the 16 data bits on rising edges only (two samples per bit). It closes with one low link cycle and then lets the lanes float again. Clock recovery and pad control belong to the surrounding logic.

Top module: `link_slave`

## Requirements
- R1: While `rstN` is low and right after reset, `laneOe` is 0, and `wrStrobe` and `rdReq` are 0.
- R2: In the idle state a transaction starts only when lane 0 is high in a cycle with `linkRise`=1. Lane 1 in that same sample is the direction (1 = read, 0 = write). A high lane 0 in a falling-edge cycle is ignored and leads to neither a write strobe nor a read request.
- R3: The second sample of a transaction gives the address/data flag on lane 0 and the chip-select bit on lane 1. From the cycle after that sample, these appear on `cmdAddrFlag` and `cmdChipSel` and stay there until the next transaction.
- R4: In a write, the 8 samples after the header carry `wrData` bits 0..7 on lane 0 and bits 8..15 on lane 1, least significant bit first. Lane 0 levels inside the payload do not restart a transaction.
- R5: `wrStrobe` is high for exactly one cycle: the cycle after the last payload sample (edge 11 of the transaction). During that cycle `wrData` holds the full word and the lanes are not driven.
- R6: For a read, `rdReq` is high for exactly one cycle, in the cycle of edge 3. The lanes are still not driven in that cycle.
- R7: After a read header the lanes stay undriven up to edge `TURN_EDGE`-1. From edge `TURN_EDGE` (default 8, allowed range 4..14, counted with the start bit as edge 1) both lanes are driven low.
- R8: While `rdReady` is low, both lanes stay driven low for as long as needed.
- R9: When `rdReady` is high in a falling-edge cycle of the waiting phase, `rdData` is captured. Both lanes are then driven high for two cycles, starting on a rising-edge cycle.
- R10: After the start mark, bit i of the captured word goes out on lane 0 and bit 8+i on lane 1, for i = 0..7 in order. Each bit is held for two cycles (one link cycle).
- R11: After the last data bit, both lanes are driven low for two cycles and then released. The block is then idle again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, one cycle per link-clock edge |
| rstN | input | 1 | Active-low synchronous reset |
| linkRise | input | 1 | High in cycles that are rising link-clock edges |
| laneIn | input | 2 | Sampled level of lanes 1 and 0 |
| laneOut | output | 2 | Level driven onto lanes 1 and 0 |
| laneOe | output | 2 | Output enable for lanes 1 and 0 |
| cmdAddrFlag | output | 1 | Address/data flag of the latest transaction |
| cmdChipSel | output | 1 | Chip-select bit of the latest transaction |
| wrStrobe | output | 1 | One-cycle write strobe |
| wrData | output | 16 | Assembled write payload |
| rdReq | output | 1 | One-cycle read request |
| rdReady | input | 1 | Read data is valid |
| rdData | input | 16 | Read data word |

## Verification
An edge counter that slips by one shows up as a strobe one cycle early or late, or as a payload shifted by one bit with the top bit lost. The bench sees either within the same transaction, at edge 11. A wrong turnaround count changes the first cycle in which `laneOe` goes high, which is known to the exact edge. A wrong start-mark phase or a wrong shift cadence in the read path shows as a mark starting in a falling-edge cycle, or as wrong lane levels within the first two data cycles. Each of these is caught in the first read that exercises it.

// File: rtl/link_slave_pkg.sv
package link_slave_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_WDATA,
    ST_TURN,
    ST_LOWWAIT,
    ST_START,
    ST_RDATA,
    ST_TAIL
  } phaseT;

  // Strobes from control to datapath
  typedef struct packed {
    logic capHdr;     // latch flag and chip-select bits
    logic shiftIn;    // shift one write bit per lane
    logic loadRd;     // capture read word
    logic shiftOut;   // advance read word by one bit
    logic driveHigh;  // start mark on both lanes
    logic driveData;  // payload bits on the lanes
  } ctlT;

endpackage

// File: rtl/link_slave_ctrl.sv
module link_slave_ctrl
  import link_slave_pkg::*;
#(
  parameter int LANE_BITS = 8,
  parameter int TURN_EDGE = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       linkRise,
  input  logic [1:0] laneIn,
  input  logic       rdReady,
  output ctlT        ctl,
  output logic       driveEn,
  output logic       wrStrobe,
  output logic       rdReq
);

  localparam int CNT_W = $clog2(2 * LANE_BITS + 16);
  localparam logic [CNT_W-1:0] LAST_WBIT  = CNT_W'(LANE_BITS - 1);
  localparam logic [CNT_W-1:0] LAST_RSLOT = CNT_W'(2 * LANE_BITS - 1);
  localparam logic [CNT_W-1:0] TURN_LAST  = CNT_W'(TURN_EDGE - 1);
  localparam logic [CNT_W-1:0] FIRST_TURN = CNT_W'(3);
  localparam logic [CNT_W-1:0] ONE        = CNT_W'(1);

  phaseT            state;
  logic [CNT_W-1:0] cnt;
  logic             isRead;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      isRead   <= 1'b0;
      wrStrobe <= 1'b0;
      rdReq    <= 1'b0;
    end else begin
      wrStrobe <= 1'b0;
      rdReq    <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (linkRise && laneIn[0]) begin
            isRead <= laneIn[1];
            state  <= ST_HDR;
          end
        end
        ST_HDR: begin
          if (isRead) begin
            state <= ST_TURN;
            cnt   <= FIRST_TURN;   // index of the next edge
            rdReq <= 1'b1;
          end else begin
            state <= ST_WDATA;
            cnt   <= '0;
          end
        end
        ST_WDATA: begin
          if (cnt == LAST_WBIT) begin
            state    <= ST_IDLE;
            wrStrobe <= 1'b1;
          end else begin
            cnt <= cnt + ONE;
          end
        end
        ST_TURN: begin
          if (cnt == TURN_LAST) begin
            state <= ST_LOWWAIT;
          end else begin
            cnt <= cnt + ONE;
          end
        end
        ST_LOWWAIT: begin
          if (rdReady && !linkRise) begin
            state <= ST_START;
            cnt   <= '0;
          end
        end
        ST_START: begin
          if (cnt == ONE) begin
            state <= ST_RDATA;
            cnt   <= '0;
          end else begin
            cnt <= cnt + ONE;
          end
        end
        ST_RDATA: begin
          if (cnt == LAST_RSLOT) begin
            state <= ST_TAIL;
            cnt   <= '0;
          end else begin
            cnt <= cnt + ONE;
          end
        end
        ST_TAIL: begin
          if (cnt == ONE) begin
            state <= ST_IDLE;
          end else begin
            cnt <= cnt + ONE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.capHdr    = (state == ST_HDR);
    ctl.shiftIn   = (state == ST_WDATA);
    ctl.loadRd    = (state == ST_LOWWAIT) && rdReady && !linkRise;
    ctl.shiftOut  = (state == ST_RDATA) && cnt[0];
    ctl.driveHigh = (state == ST_START);
    ctl.driveData = (state == ST_RDATA);
    driveEn       = (state == ST_LOWWAIT) || (state == ST_START) ||
                    (state == ST_RDATA)   || (state == ST_TAIL);
  end

endmodule

// File: rtl/link_slave_dp.sv
module link_slave_dp
  import link_slave_pkg::*;
#(
  parameter int LANE_BITS = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctlT                    ctl,
  input  logic [1:0]             laneIn,
  input  logic [2*LANE_BITS-1:0] rdWord,
  output logic                   cmdAddrFlag,
  output logic                   cmdChipSel,
  output logic [2*LANE_BITS-1:0] wrWord,
  output logic [1:0]             laneOut
);

  localparam int WORD_W = 2 * LANE_BITS;

  logic [LANE_BITS-1:0] inLo, inHi;
  logic [LANE_BITS-1:0] outLo, outHi;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdAddrFlag <= 1'b0;
      cmdChipSel  <= 1'b0;
      inLo        <= '0;
      inHi        <= '0;
      outLo       <= '0;
      outHi       <= '0;
    end else begin
      if (ctl.capHdr) begin
        cmdAddrFlag <= laneIn[0];
        cmdChipSel  <= laneIn[1];
      end
      if (ctl.shiftIn) begin
        // first bit received ends at position 0
        inLo <= {laneIn[0], inLo[LANE_BITS-1:1]};
        inHi <= {laneIn[1], inHi[LANE_BITS-1:1]};
      end
      if (ctl.loadRd) begin
        outLo <= rdWord[LANE_BITS-1:0];
        outHi <= rdWord[WORD_W-1:LANE_BITS];
      end else if (ctl.shiftOut) begin
        outLo <= outLo >> 1;
        outHi <= outHi >> 1;
      end
    end
  end

  assign wrWord = {inHi, inLo};

  always_comb begin
    if (ctl.driveData)      laneOut = {outHi[0], outLo[0]};
    else if (ctl.driveHigh) laneOut = 2'b11;
    else                    laneOut = 2'b00;
  end

endmodule

// File: rtl/link_slave.sv
module link_slave
  import link_slave_pkg::*;
#(
  parameter int LANE_BITS = 8,
  parameter int TURN_EDGE = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   linkRise,
  input  logic [1:0]             laneIn,
  output logic [1:0]             laneOut,
  output logic [1:0]             laneOe,
  output logic                   cmdAddrFlag,
  output logic                   cmdChipSel,
  output logic                   wrStrobe,
  output logic [2*LANE_BITS-1:0] wrData,
  output logic                   rdReq,
  input  logic                   rdReady,
  input  logic [2*LANE_BITS-1:0] rdData
);

  ctlT  ctl;
  logic driveEn;

  link_slave_ctrl #(
    .LANE_BITS(LANE_BITS),
    .TURN_EDGE(TURN_EDGE)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .linkRise (linkRise),
    .laneIn   (laneIn),
    .rdReady  (rdReady),
    .ctl      (ctl),
    .driveEn  (driveEn),
    .wrStrobe (wrStrobe),
    .rdReq    (rdReq)
  );

  link_slave_dp #(
    .LANE_BITS(LANE_BITS)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .laneIn      (laneIn),
    .rdWord      (rdData),
    .cmdAddrFlag (cmdAddrFlag),
    .cmdChipSel  (cmdChipSel),
    .wrWord      (wrData),
    .laneOut     (laneOut)
  );

  assign laneOe = {driveEn, driveEn};

endmodule

// File: rtl/link_slave_checker.sv
module link_slave_checker (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] laneOut,
  input logic [1:0] laneOe,
  input logic       wrStrobe,
  input logic       rdReq
);

  // R5: the write strobe lasts a single cycle
  a_r5_strobe_single: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |=> !wrStrobe);

  // R5: no lane is driven while a write completes
  a_r5_strobe_released: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |-> (laneOe == 2'b00));

  // R6: the read request lasts a single cycle
  a_r6_req_single: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |=> !rdReq);

  // R6: lanes are still released when the request is raised
  a_r6_req_released: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |-> (laneOe == 2'b00));

  // R7: the first driven cycle holds both lanes low
  a_r7_first_drive_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(laneOe[0]) |-> (laneOut == 2'b00));

  // R11: lanes are let go only after a low cycle
  a_r11_release_after_low: assert property (@(posedge clk) disable iff (!rstN)
    $fell(laneOe[0]) |-> ($past(laneOut) == 2'b00));

endmodule

bind link_slave link_slave_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .laneOut  (laneOut),
  .laneOe   (laneOe),
  .wrStrobe (wrStrobe),
  .rdReq    (rdReq)
);

// File: tb/link_slave_test.sv
module link_slave_test;

  localparam int LB = 8;
  localparam int TE = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        linkRise = 1'b0;
  logic [1:0]  laneIn = 2'b00;
  logic [1:0]  laneOut, laneOe;
  logic        cmdAddrFlag, cmdChipSel, wrStrobe, rdReq;
  logic [15:0] wrData;
  logic        rdReady = 1'b0;
  logic [15:0] rdData = 16'h0000;

  int  checks = 0;
  int  fails = 0;
  bit  phase = 1'b1;   // linkRise value of the next stepped cycle
  bit  done = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  link_slave #(.LANE_BITS(LB), .TURN_EDGE(TE)) uut (
    .clk(clk), .rstN(rstN), .linkRise(linkRise), .laneIn(laneIn),
    .laneOut(laneOut), .laneOe(laneOe), .cmdAddrFlag(cmdAddrFlag),
    .cmdChipSel(cmdChipSel), .wrStrobe(wrStrobe), .wrData(wrData),
    .rdReq(rdReq), .rdReady(rdReady), .rdData(rdData)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // one link edge: drive at negedge, return just after the posedge
  task automatic step(input logic l0, input logic l1);
    @(negedge clk);
    laneIn   = {l1, l0};
    linkRise = phase;
    phase    = ~phase;
    @(posedge clk);
    #1;
  endtask

  task automatic align();
    if (!phase) step(1'b0, 1'b0);
  endtask

  task automatic doWrite(input logic ad, input logic cs, input logic [15:0] d);
    align();
    step(1'b1, 1'b0);
    step(ad, cs);
    chk(cmdAddrFlag == ad && cmdChipSel == cs, "R3 header",
        {30'd0, cmdChipSel, cmdAddrFlag}, {30'd0, cs, ad});
    for (int i = 0; i < LB; i++) begin
      step(d[i], d[LB+i]);
      if (i < LB - 1)
        chk(wrStrobe == 1'b0, "R5 early strobe", {31'd0, wrStrobe}, 32'd0);
    end
    chk(wrStrobe == 1'b1, "R5 strobe", {31'd0, wrStrobe}, 32'd1);
    chk(wrData == d, "R4 payload", {16'd0, wrData}, {16'd0, d});
    chk(laneOe == 2'b00, "R5 lanes released", {30'd0, laneOe}, 32'd0);
    step(1'b0, 1'b0);
    chk(wrStrobe == 1'b0, "R5 single pulse", {31'd0, wrStrobe}, 32'd0);
  endtask

  task automatic doRead(input logic ad, input logic cs, input logic [15:0] d,
                        input int waitN);
    int guard;
    align();
    step(1'b1, 1'b1);
    step(ad, cs);
    chk(rdReq == 1'b1, "R6 request", {31'd0, rdReq}, 32'd1);
    chk(cmdAddrFlag == ad && cmdChipSel == cs, "R3 header",
        {30'd0, cmdChipSel, cmdAddrFlag}, {30'd0, cs, ad});
    for (int e = 3; e < TE; e++) begin
      chk(laneOe == 2'b00, "R7 released before turn", {30'd0, laneOe}, 32'd0);
      step(1'b0, 1'b0);
      if (e == 3) chk(rdReq == 1'b0, "R6 single pulse", {31'd0, rdReq}, 32'd0);
    end
    chk(laneOe == 2'b11 && laneOut == 2'b00, "R7 driven low at turn edge",
        {28'd0, laneOe, laneOut}, {28'd0, 4'b1100});
    for (int w = 0; w < waitN; w++) begin
      step(1'b0, 1'b0);
      chk(laneOe == 2'b11 && laneOut == 2'b00, "R8 hold low",
          {28'd0, laneOe, laneOut}, {28'd0, 4'b1100});
    end
    rdReady = 1'b1;
    rdData  = d;
    guard   = 0;
    while (!(laneOe == 2'b11 && laneOut == 2'b11) && guard < 4) begin
      step(1'b0, 1'b0);
      guard++;
    end
    rdReady = 1'b0;
    rdData  = ~d;
    chk(laneOe == 2'b11 && laneOut == 2'b11, "R9 start mark",
        {28'd0, laneOe, laneOut}, {28'd0, 4'b1111});
    chk(phase == 1'b1, "R9 mark on rising edge", {31'd0, phase}, 32'd1);
    step(1'b0, 1'b0);
    chk(laneOut == 2'b11, "R9 mark two cycles", {30'd0, laneOut}, 32'd3);
    step(1'b0, 1'b0);
    for (int i = 0; i < LB; i++) begin
      for (int h = 0; h < 2; h++) begin
        chk(laneOe == 2'b11 && laneOut == {d[LB+i], d[i]}, "R10 data bit",
            {28'd0, laneOe, laneOut}, {28'd0, 2'b11, d[LB+i], d[i]});
        step(1'b1, 1'b1);   // lane input noise is ignored
      end
    end
    chk(laneOe == 2'b11 && laneOut == 2'b00, "R11 tail low 1",
        {28'd0, laneOe, laneOut}, {28'd0, 4'b1100});
    step(1'b0, 1'b0);
    chk(laneOe == 2'b11 && laneOut == 2'b00, "R11 tail low 2",
        {28'd0, laneOe, laneOut}, {28'd0, 4'b1100});
    step(1'b0, 1'b0);
    chk(laneOe == 2'b00, "R11 release", {30'd0, laneOe}, 32'd0);
  endtask

  task automatic fallingStart(input logic dir);
    align();
    step(1'b0, 1'b0);     // rising, idle
    step(1'b1, dir);      // lane 0 high on a falling edge
    for (int k = 0; k < 14; k++) begin
      step(1'b0, 1'b0);
      chk(wrStrobe == 1'b0 && rdReq == 1'b0 && laneOe == 2'b00,
          "R2 falling-edge high ignored",
          {28'd0, wrStrobe, rdReq, laneOe}, 32'd0);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(laneOe == 2'b00 && wrStrobe == 1'b0 && rdReq == 1'b0, "R1 in reset",
        {28'd0, wrStrobe, rdReq, laneOe}, 32'd0);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #1;
    chk(laneOe == 2'b00 && wrStrobe == 1'b0 && rdReq == 1'b0, "R1 after reset",
        {28'd0, wrStrobe, rdReq, laneOe}, 32'd0);

    fallingStart(1'b0);
    fallingStart(1'b1);

    for (int k = 0; k < 16; k++)
      doWrite(k[0], k[1], 16'h0001 << k);
    doWrite(1'b1, 1'b1, 16'hFFFF);
    doWrite(1'b0, 1'b0, 16'h0000);
    doWrite(1'b1, 1'b0, 16'hA53C);
    doWrite(1'b0, 1'b1, 16'h5AC3);

    for (int k = 0; k < 8; k++)
      doRead(k[0], k[1], 16'((k * 16'h1357) ^ 16'hC3A5), k % 4);
    doRead(1'b1, 1'b1, 16'hFFFF, 5);
    doRead(1'b0, 1'b0, 16'h0000, 0);

    // write right after a read
    doWrite(1'b1, 1'b0, 16'h8001);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule